// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Controller

Two small fixed-priority interrupt controllers, a master and a slave, are joined by cascade logic. Each controller latches requests on eight lines, masks every line at or below the most urgent line already in service, and picks the lowest-numbered eligible line. The slave's interrupt output does not go to the processor. It enters the master on whichever master line the master's cascade map marks. The master alone drives the processor interrupt line.

The processor answers with two active-low acknowledge pulses, which are sampled on the clock. If a plain master line won, the master commits it on the first pulse and drives its vector during the second. If a cascaded line won, the master drives no vector. It puts the winning line index on three cascade lines from the end of the first pulse to the end of the second. The slave compares that code with its programmed identity. On a match it commits its own winner and drives its vector during the second pulse. Each bus driver is modelled as a value plus a drive enable.

Top module: `picc_pair`

## Requirements
- R1: Each controller grants the lowest-numbered eligible pending line. `cpu_int` is high whenever the master has an eligible line, counting a cascaded line whose slave interrupt is high.
- R2: A line in service blocks itself and every higher-numbered line until an end-of-interrupt write (`eoi_we`, `eoi_sel` 0 master / 1 slave, `eoi_line`) clears it. A lower-numbered line is still granted.
- R3: A master line whose bit is 1 in the cascade map (config address 0) follows the slave interrupt output. `mst_req` on that line has no effect.
- R4: When a non-cascaded master line wins, `mst_oe` is high for the whole second pulse with `mst_dout` = {master base[7:3], line index}, and `cas_id` stays 0.
- R5: When a cascaded master line wins, `cas_id` carries that line's index from the cycle after the first pulse ends until the second pulse ends, and `mst_oe` stays low.
- R6: The slave drives `slv_oe` with `slv_dout` = {slave base[7:3], its winning index} during the second pulse only if `cas_id` equals bits 2:0 of its identity (config address 1, upper bits ignored). Otherwise its pending and in-service state is unchanged.
- R7: `mst_oe` and `slv_oe` are never high in the same cycle.
- R8: After reset `cpu_int`, `cas_id`, `mst_oe` and `slv_oe` are 0 and no line is pending or in service.
- R9: The master commits its winner on the first clock that samples `inta_n` low from idle. The sequence runs first pulse, gap, second pulse, then idle. A sequence with no eligible request drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_req | input | 8 | Master request lines |
| slv_req | input | 8 | Slave request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 master cascade map, 1 slave identity, 2 master base, 3 slave base |
| cfg_data | input | 8 | Configuration write data |
| eoi_we | input | 1 | End-of-interrupt strobe |
| eoi_sel | input | 1 | 0 master, 1 slave |
| eoi_line | input | 3 | Line whose in-service bit is cleared |
| inta_n | input | 1 | Active-low acknowledge pulse input |
| cpu_int | output | 1 | Interrupt request to the processor |
| cas_id | output | 3 | Cascade identification lines |
| mst_dout | output | 8 | Master vector value |
| mst_oe | output | 1 | Master vector drive enable |
| slv_dout | output | 8 | Slave vector value |
| slv_oe | output | 1 | Slave vector drive enable |

## Verification
A wrong pending or in-service bit shows within one clock as a wrong level on `cpu_int`: a line stays blocked, or a lower-priority line wins early. A wrong latched winner or cascade flag shows on the next acknowledge as a wrong `cas_id` in the gap cycle, or as the wrong drive enable or vector in the second pulse. A slave that has lost track of its state shows only after the master's end-of-interrupt, when the master raises `cpu_int` again for a request the slave still holds. Comparing every output on every clock against a behavioural model catches each of these in the cycle it appears.

// File: rtl/picc_pkg.sv
package picc_pkg;
    localparam int unsigned LINES = 8;
    localparam int unsigned IDX_W = $clog2(LINES);
    localparam int unsigned VEC_W = 8;

    typedef enum logic [1:0] {
        ACK_IDLE,
        ACK_FIRST,
        ACK_GAP,
        ACK_SECOND
    } ack_state_t;

    typedef struct packed {
        logic             ok;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic pick_t lowest_set(input logic [LINES-1:0] v);
        pick_t r;
        r = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.ok  = 1'b1;
                r.idx = i[IDX_W-1:0];
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/picc_resolver.sv
module picc_resolver
    import picc_pkg::*;
(
    input  logic [LINES-1:0] req,
    input  logic [LINES-1:0] isr,
    output pick_t            win
);
    logic [LINES-1:0] blocked;
    logic [LINES-1:0] elig;

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_blk
            assign blocked[g] = |isr[g:0];
        end
    endgenerate

    assign elig = req & ~blocked;
    assign win  = lowest_set(elig);
endmodule

// File: rtl/picc_ack_seq.sv
module picc_ack_seq
    import picc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       inta_n,
    output ack_state_t state,
    output logic       start_first,
    output logic       start_second
);
    ack_state_t st_n;

    assign start_first  = (state == ACK_IDLE) && !inta_n;
    assign start_second = (state == ACK_GAP) && !inta_n;

    always_comb begin
        case (state)
            ACK_IDLE:   st_n = inta_n ? ACK_IDLE : ACK_FIRST;
            ACK_FIRST:  st_n = inta_n ? ACK_GAP : ACK_FIRST;
            ACK_GAP:    st_n = inta_n ? ACK_GAP : ACK_SECOND;
            ACK_SECOND: st_n = inta_n ? ACK_IDLE : ACK_SECOND;
            default:    st_n = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ACK_IDLE;
        else     state <= st_n;
    end

    AST_SECOND_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
        (state == ACK_SECOND) |-> ($past(state) == ACK_GAP || $past(state) == ACK_SECOND)); // R9
endmodule

// File: rtl/picc_ctrl.sv
module picc_ctrl
    import picc_pkg::*;
#(
    parameter bit IS_SLAVE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] req,
    input  logic             casc_level,
    input  logic [IDX_W-1:0] cas_in,
    input  logic             cfg_we,
    input  logic             base_we,
    input  logic [VEC_W-1:0] cfg_d,
    input  logic             eoi_we,
    input  logic [IDX_W-1:0] eoi_line,
    input  logic             inta_n,
    output logic             int_o,
    output logic [IDX_W-1:0] cas_o,
    output logic [VEC_W-1:0] dout,
    output logic             oe
);
    logic [VEC_W-1:0] cfg_q;
    logic [VEC_W-1:0] base_q;
    logic [LINES-1:0] pend_q;
    logic [LINES-1:0] isr_q;
    pick_t            win_q;
    logic             casc_q;

    logic [LINES-1:0] casc_map;
    logic [LINES-1:0] eff;
    logic [LINES-1:0] hot;
    logic [LINES-1:0] eoi_mask;
    pick_t            cur;
    ack_state_t       state;
    logic             start_first;
    logic             start_second;
    logic             id_match;
    logic             commit;
    logic             latch_win;
    logic             cas_window;

    assign casc_map = IS_SLAVE ? '0 : cfg_q[LINES-1:0];
    assign eff      = (pend_q & ~casc_map) | (casc_map & {LINES{casc_level}});

    picc_resolver u_res (
        .req (eff),
        .isr (isr_q),
        .win (cur)
    );

    picc_ack_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .inta_n       (inta_n),
        .state        (state),
        .start_first  (start_first),
        .start_second (start_second)
    );

    assign id_match  = (cas_in == cfg_q[IDX_W-1:0]);
    assign commit    = IS_SLAVE ? (start_second && cur.ok && id_match) : (start_first && cur.ok);
    assign latch_win = IS_SLAVE ? start_second : start_first;
    assign hot       = commit ? (LINES'(1) << cur.idx) : '0;
    assign eoi_mask  = eoi_we ? (LINES'(1) << eoi_line) : '0;

    always_ff @(posedge clk) begin
        if (cfg_we)  cfg_q  <= cfg_d;
        if (base_we) base_q <= cfg_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            isr_q  <= '0;
            win_q  <= '0;
            casc_q <= 1'b0;
        end else begin
            pend_q <= (pend_q | req) & ~hot;
            isr_q  <= (isr_q | hot) & ~eoi_mask;
            if (latch_win) begin
                win_q.ok  <= commit;
                win_q.idx <= cur.idx;
                casc_q    <= commit && casc_map[cur.idx];
            end
        end
    end

    assign cas_window = (state == ACK_GAP) || (state == ACK_SECOND);
    assign int_o = cur.ok;
    assign cas_o = (cas_window && casc_q) ? win_q.idx : '0;
    assign oe    = (state == ACK_SECOND) && win_q.ok && !casc_q;
    assign dout  = {base_q[VEC_W-1:IDX_W], win_q.idx};

    AST_ONE_NEW_ISR: assert property (@(posedge clk) disable iff (rst)
        $countones(isr_q & ~$past(isr_q)) <= 1); // R2
    AST_CLAIM_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        (IS_SLAVE && oe) |-> (cas_in == cfg_q[IDX_W-1:0])); // R6
endmodule

// File: rtl/picc_pair.sv
module picc_pair
    import picc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] mst_req,
    input  logic [LINES-1:0] slv_req,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [VEC_W-1:0] cfg_data,
    input  logic             eoi_we,
    input  logic             eoi_sel,
    input  logic [IDX_W-1:0] eoi_line,
    input  logic             inta_n,
    output logic             cpu_int,
    output logic [IDX_W-1:0] cas_id,
    output logic [VEC_W-1:0] mst_dout,
    output logic             mst_oe,
    output logic [VEC_W-1:0] slv_dout,
    output logic             slv_oe
);
    logic             slv_int;
    logic [IDX_W-1:0] m_cas;
    logic [IDX_W-1:0] s_cas;

    picc_ctrl #(.IS_SLAVE(1'b0)) u_mst (
        .clk        (clk),
        .rst        (rst),
        .req        (mst_req),
        .casc_level (slv_int),
        .cas_in     ('0),
        .cfg_we     (cfg_we && cfg_addr == 2'd0),
        .base_we    (cfg_we && cfg_addr == 2'd2),
        .cfg_d      (cfg_data),
        .eoi_we     (eoi_we && !eoi_sel),
        .eoi_line   (eoi_line),
        .inta_n     (inta_n),
        .int_o      (cpu_int),
        .cas_o      (m_cas),
        .dout       (mst_dout),
        .oe         (mst_oe)
    );

    picc_ctrl #(.IS_SLAVE(1'b1)) u_slv (
        .clk        (clk),
        .rst        (rst),
        .req        (slv_req),
        .casc_level (1'b0),
        .cas_in     (m_cas),
        .cfg_we     (cfg_we && cfg_addr == 2'd1),
        .base_we    (cfg_we && cfg_addr == 2'd3),
        .cfg_d      (cfg_data),
        .eoi_we     (eoi_we && eoi_sel),
        .eoi_line   (eoi_line),
        .inta_n     (inta_n),
        .int_o      (slv_int),
        .cas_o      (s_cas),
        .dout       (slv_dout),
        .oe         (slv_oe)
    );

    assign cas_id = m_cas | s_cas;

    AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (rst)
        !(mst_oe && slv_oe)); // R7
    AST_MASTER_QUIET_ON_CASCADE: assert property (@(posedge clk) disable iff (rst)
        mst_oe |-> (cas_id == '0)); // R5
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!cpu_int && !mst_oe && !slv_oe && cas_id == '0)); // R8
endmodule

// File: tb/tb_picc_pair.sv
`timescale 1ns/1ps
module tb_picc_pair;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mst_req = '0, slv_req = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_data = '0;
    logic       eoi_we = 1'b0, eoi_sel = 1'b0;
    logic [2:0] eoi_line = '0;
    logic       inta_n = 1'b1;
    logic       cpu_int, mst_oe, slv_oe;
    logic [2:0] cas_id;
    logic [7:0] mst_dout, slv_dout;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    picc_pair dut (
        .clk(clk), .rst(rst), .mst_req(mst_req), .slv_req(slv_req),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .eoi_we(eoi_we), .eoi_sel(eoi_sel), .eoi_line(eoi_line),
        .inta_n(inta_n), .cpu_int(cpu_int), .cas_id(cas_id),
        .mst_dout(mst_dout), .mst_oe(mst_oe), .slv_dout(slv_dout), .slv_oe(slv_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [7:0] m_pend, s_pend, m_isr, s_isr;
    logic [7:0] m_map = '0, s_idr = '0, m_base = '0, s_base = '0;
    int st, m_ok, m_idx, m_casc, s_ok, s_idx;

    function automatic int win_of(logic [7:0] p, logic [7:0] is, logic [7:0] map, bit lvl);
        for (int i = 0; i < 8; i++) begin
            if (is[i]) return -1;
            if (map[i] ? lvl : p[i]) return i;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        int sw, mw, cas, e_cas;
        logic [7:0] mh, sh, me, se;
        if (cfg_we) begin
            case (cfg_addr)
                2'd0: m_map = cfg_data;
                2'd1: s_idr = cfg_data;
                2'd2: m_base = cfg_data;
                default: s_base = cfg_data;
            endcase
        end
        if (rst) begin
            m_pend = 0; s_pend = 0; m_isr = 0; s_isr = 0;
            st = 0; m_ok = 0; m_idx = 0; m_casc = 0; s_ok = 0; s_idx = 0;
        end else begin
            sw  = win_of(s_pend, s_isr, 8'h00, 1'b0);
            mw  = win_of(m_pend, m_isr, m_map, sw >= 0);
            cas = ((st == 2 || st == 3) && m_casc != 0) ? m_idx : 0;
            mh = 0; sh = 0;
            if (st == 0 && !inta_n) begin
                m_ok   = (mw >= 0);
                m_idx  = m_ok ? mw : 0;
                m_casc = m_ok && m_map[m_idx];
                if (m_ok) mh[mw] = 1'b1;
            end
            if (st == 2 && !inta_n) begin
                s_ok  = (sw >= 0) && (cas == int'(s_idr[2:0]));
                s_idx = (sw >= 0) ? sw : 0;
                if (s_ok) sh[sw] = 1'b1;
            end
            me = (eoi_we && !eoi_sel) ? (8'd1 << eoi_line) : 8'd0;
            se = (eoi_we && eoi_sel) ? (8'd1 << eoi_line) : 8'd0;
            m_pend = (m_pend | mst_req) & ~mh;
            s_pend = (s_pend | slv_req) & ~sh;
            m_isr  = (m_isr | mh) & ~me;
            s_isr  = (s_isr | sh) & ~se;
            case (st)
                0: st = inta_n ? 0 : 1;
                1: st = inta_n ? 2 : 1;
                2: st = inta_n ? 2 : 3;
                default: st = inta_n ? 0 : 3;
            endcase
        end
        #1;
        if (!rst) begin
            sw    = win_of(s_pend, s_isr, 8'h00, 1'b0);
            mw    = win_of(m_pend, m_isr, m_map, sw >= 0);
            e_cas = ((st == 2 || st == 3) && m_casc != 0) ? m_idx : 0;
            chk("R1 cpu_int", cpu_int, mw >= 0);
            chk("R5 cas_id", cas_id, e_cas);
            chk("R4 mst_oe", mst_oe, st == 3 && m_ok != 0 && m_casc == 0);
            chk("R6 slv_oe", slv_oe, st == 3 && s_ok != 0);
            chk("R7 one driver", int'(mst_oe) + int'(slv_oe) <= 1, 1);
            if (mst_oe) chk("R4 mst_dout", mst_dout, {m_base[7:3], 3'(m_idx)});
            if (slv_oe) chk("R6 slv_dout", slv_dout, {s_base[7:3], 3'(s_idx)});
        end
    end

    task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_req(input logic [7:0] m, input logic [7:0] s);
        @(negedge clk); mst_req = m; slv_req = s;
        @(negedge clk); mst_req = '0; slv_req = '0;
        @(negedge clk);
    endtask

    task automatic eoi(input logic sel, input logic [2:0] line);
        @(negedge clk); eoi_we = 1'b1; eoi_sel = sel; eoi_line = line;
        @(negedge clk); eoi_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic ack(output logic [2:0] cg, output logic mo, output logic so,
                       output logic [7:0] md, output logic [7:0] sd);
        @(negedge clk); inta_n = 1'b0;
        @(negedge clk); inta_n = 1'b1;
        @(negedge clk); cg = cas_id; inta_n = 1'b0;
        @(negedge clk); mo = mst_oe; so = slv_oe; md = mst_dout; sd = slv_dout; inta_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [2:0] cg;
        logic mo, so;
        logic [7:0] md, sd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 cpu_int after reset", cpu_int, 0);
        chk("R8 cas_id after reset", cas_id, 0);
        chk("R8 drivers after reset", {mst_oe, slv_oe}, 0);

        cfg_write(2'd0, 8'h04);
        cfg_write(2'd1, 8'h02);
        cfg_write(2'd2, 8'h08);
        cfg_write(2'd3, 8'h70);
        chk("R8 idle after config", cpu_int, 0);

        // plain master line
        pulse_req(8'h20, 8'h00);
        chk("R1 line5 raises cpu_int", cpu_int, 1);
        ack(cg, mo, so, md, sd);
        chk("R4 cas zero for plain win", cg, 0);
        chk("R4 master drives", {mo, so}, 2'b10);
        chk("R4 master vector", md, 8'h0D);
        chk("R9 request consumed on first pulse", cpu_int, 0);
        eoi(1'b0, 3'd5);
        chk("R9 no re-request after eoi", cpu_int, 0);

        // priority and in-service blocking
        pulse_req(8'h48, 8'h00);
        ack(cg, mo, so, md, sd);
        chk("R1 lowest index wins", md, 8'h0B);
        chk("R2 line6 blocked by line3", cpu_int, 0);
        eoi(1'b0, 3'd3);
        chk("R2 line6 released by eoi", cpu_int, 1);
        ack(cg, mo, so, md, sd);
        chk("R2 line6 vector", md, 8'h0E);
        eoi(1'b0, 3'd6);

        // cascaded line ignores master input
        pulse_req(8'h04, 8'h00);
        chk("R3 master input on cascaded line ignored", cpu_int, 0);

        // slave served through cascade
        pulse_req(8'h00, 8'h02);
        chk("R3 slave request reaches cpu_int", cpu_int, 1);
        ack(cg, mo, so, md, sd);
        chk("R5 cascade code", cg, 2);
        chk("R5 slave owns bus", {mo, so}, 2'b01);
        chk("R6 slave vector", sd, 8'h71);
        eoi(1'b1, 3'd1);
        eoi(1'b0, 3'd2);
        chk("R2 all clear", cpu_int, 0);

        // master line 0 beats cascaded line 2
        pulse_req(8'h01, 8'h10);
        ack(cg, mo, so, md, sd);
        chk("R1 line0 beats cascade", {mo, so, md}, {2'b10, 8'h08});
        chk("R2 line0 in service blocks cascade", cpu_int, 0);
        eoi(1'b0, 3'd0);
        chk("R2 cascade released", cpu_int, 1);
        ack(cg, mo, so, md, sd);
        chk("R6 slave line4 vector", {so, sd}, {1'b1, 8'h74});
        eoi(1'b1, 3'd4);
        eoi(1'b0, 3'd2);

        // identity mismatch, then upper bits ignored
        cfg_write(2'd1, 8'h03);
        pulse_req(8'h00, 8'h01);
        ack(cg, mo, so, md, sd);
        chk("R5 code still broadcast", cg, 2);
        chk("R6 mismatched slave silent", {mo, so}, 2'b00);
        eoi(1'b0, 3'd2);
        chk("R6 slave request kept on mismatch", cpu_int, 1);
        cfg_write(2'd1, 8'hFA);
        ack(cg, mo, so, md, sd);
        chk("R6 low three bits match", {so, sd}, {1'b1, 8'h70});
        eoi(1'b1, 3'd0);
        eoi(1'b0, 3'd2);

        // acknowledge with nothing pending
        ack(cg, mo, so, md, sd);
        chk("R9 empty acknowledge drives nothing", {cg, mo, so}, 5'b0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule